// File: doc/BRIEF.md
# Line Dimmer Type Classifier

This block decides how a phase-controlled AC line feeding a lighting driver is being dimmed. It watches a stream of digitised rectified-line samples along with a strobe that marks the start of every half line cycle. From the shape of each half cycle it picks one of three operating modes: no dimmer, a leading-edge dimmer or a trailing-edge dimmer. The boost controller downstream then runs the algorithm that matches the reported mode.

Operation begins when `start_en` rises, which happens when the supply leaves undervoltage lockout. The state machine first discards the half cycle already in progress (`ST_ALIGN`). It then spends `LEARN_HC` complete half cycles, two line cycles by default, in `ST_LEARN` and takes a majority vote over them. After the vote it moves to `ST_VALID`, where the mode is reported as valid. In `ST_VALID` it samples one half cycle out of every `VAL_HC` to confirm the choice. A saturating miss counter smooths these confirmation results. When `MISS_LIM` confirmations in a row disagree with the running mode, the machine leaves `ST_VALID` and relearns. Whenever `start_en` drops, every state returns to `ST_IDLE`.

The machine has four named transitions: IDLE→ALIGN on `start_en`, ALIGN→LEARN on the first boundary, LEARN→VALID on the vote, and VALID→LEARN on a filter trip. A further transition takes any state back to IDLE when `start_en` is low.

Top module: `dimmer_classifier`

## Requirements
- R1: While `rst_n` is low (sampled at a clock edge), the outputs after that edge are `mode`=00, `mode_valid`=0, `learning`=0 and `validating`=0. After reset the block stays in this idle state until `start_en` is sampled high.
- R2: `learning` goes high on the cycle after `start_en` is first sampled high. The half cycle in progress at that moment, which ends at the first strobe, is discarded. `mode_valid` stays low for the whole learn phase.
- R3: Each completed half cycle is classified as follows. It is leading-edge if any of its first `LEAD_WIN` samples is at or above `LEAD_LVL`. Otherwise it is trailing-edge if two consecutive samples within it fall by more than `SLOPE_TH`. Otherwise it is no-dimmer. The leading-edge test takes priority over the trailing-edge test.
- R4: After `LEARN_HC` classified half cycles the block enters the validate phase and reports a mode. The mode is leading-edge (`mode`=01) if more than half of those half cycles were leading, otherwise trailing-edge (10) if more than half were trailing, and otherwise no-dimmer (00). `mode_valid` and `validating` rise together 2 cycles after the strobe that closes the last learn half cycle. The code 11 is never output.
- R5: In the validate phase, only every `VAL_HC`-th half-cycle result, counted from entry, is compared against the running mode. Half cycles between these checks have no effect.
- R6: A check that disagrees with the mode increments a miss count, and a check that agrees clears it. When the count reaches `MISS_LIM`, the block returns to learning and `mode_valid` drops. Fewer consecutive misses leave the mode and `mode_valid` unchanged.
- R7: When `start_en` is sampled low, the block is idle on the next cycle (`learning`=0, `validating`=0, `mode_valid`=0, `mode`=00), whatever state it was in.
- R8: A sample that arrives in the same cycle as the half-cycle strobe is the first sample (index 0) of the new half cycle, not the last sample of the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_en | input | 1 | High once the supply is out of lockout |
| hc_strobe | input | 1 | One-cycle pulse at each half-cycle start |
| smp_valid | input | 1 | Line sample present this cycle |
| smp | input | SMP_W | Rectified line sample, unsigned |
| mode | output | 2 | 00 no dimmer, 01 leading, 10 trailing (00 when not valid) |
| mode_valid | output | 1 | Mode is trustworthy (validate phase) |
| learning | output | 1 | Align or learn phase active |
| validating | output | 1 | Validate phase active |

## Verification
Two events can land in the same cycle: the half-cycle strobe, which closes the old verdict, and a line sample, which opens the new half cycle. The bench drives every half cycle so that its first sample coincides with the strobe. It also uses a pattern whose only high value is that coinciding sample, so the mode comes out leading only if the sample is credited to the new half cycle. A reference model, built on a sample queue and a list of learn results, predicts `mode` and both phase flags on every clock. The comparison therefore also catches any error in which half cycle a strobe closes.

// File: rtl/dimclass_pkg.sv
package dimclass_pkg;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'b00,
        MODE_LEAD  = 2'b01,
        MODE_TRAIL = 2'b10
    } dim_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ALIGN = 2'b01,
        ST_LEARN = 2'b10,
        ST_VALID = 2'b11
    } cls_state_e;

endpackage

// File: rtl/dc_edge_probe.sv
module dc_edge_probe
    import dimclass_pkg::*;
#(
    parameter int SMP_W    = 10,
    parameter int LEAD_WIN = 3,
    parameter int LEAD_LVL = 400,
    parameter int SLOPE_TH = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hc_strobe,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp,
    output logic             hc_done,
    output dim_mode_e        hc_cls
);
    localparam int IDX_W = $clog2(LEAD_WIN + 1);
    localparam logic [SMP_W-1:0] LVL   = SMP_W'(LEAD_LVL);
    localparam logic [SMP_W-1:0] SLOPE = SMP_W'(SLOPE_TH);

    logic [IDX_W-1:0] idx;
    logic [SMP_W-1:0] prev;
    logic             have_prev;
    logic             lead_f, trail_f;
    logic             lead_mid, fall_hit, lead_first;
    dim_mode_e        cls_now;

    always_comb begin
        lead_first = (smp >= LVL);
        lead_mid   = (idx < IDX_W'(LEAD_WIN)) && (smp >= LVL);
        fall_hit   = have_prev && (prev > smp) && ((prev - smp) > SLOPE);
        if (lead_f)       cls_now = MODE_LEAD;
        else if (trail_f) cls_now = MODE_TRAIL;
        else              cls_now = MODE_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            prev      <= '0;
            have_prev <= 1'b0;
            lead_f    <= 1'b0;
            trail_f   <= 1'b0;
            hc_done   <= 1'b0;
            hc_cls    <= MODE_NONE;
        end else begin
            hc_done <= hc_strobe;
            if (hc_strobe) begin
                hc_cls  <= cls_now;
                trail_f <= 1'b0;
                if (smp_valid) begin
                    // coinciding sample opens the new half cycle
                    idx       <= IDX_W'(1);
                    lead_f    <= lead_first;
                    prev      <= smp;
                    have_prev <= 1'b1;
                end else begin
                    idx       <= '0;
                    lead_f    <= 1'b0;
                    have_prev <= 1'b0;
                end
            end else if (smp_valid) begin
                if (idx < IDX_W'(LEAD_WIN)) idx <= idx + IDX_W'(1);
                lead_f    <= lead_f | lead_mid;
                trail_f   <= trail_f | fall_hit;
                prev      <= smp;
                have_prev <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dc_learn_tally.sv
module dc_learn_tally
    import dimclass_pkg::*;
#(
    parameter int LEARN_HC = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      hc_done,
    input  dim_mode_e hc_cls,
    output logic      verdict_rdy,
    output dim_mode_e verdict
);
    localparam int CW   = $clog2(LEARN_HC + 1);
    localparam int HALF = LEARN_HC / 2;

    logic [CW-1:0] n_tot, n_lead, n_trail;
    logic [CW-1:0] lead_nx, trail_nx;

    always_comb begin
        lead_nx     = n_lead  + ((hc_cls == MODE_LEAD)  ? CW'(1) : CW'(0));
        trail_nx    = n_trail + ((hc_cls == MODE_TRAIL) ? CW'(1) : CW'(0));
        verdict_rdy = hc_done && (n_tot == CW'(LEARN_HC - 1));
        if (lead_nx > CW'(HALF))       verdict = MODE_LEAD;
        else if (trail_nx > CW'(HALF)) verdict = MODE_TRAIL;
        else                           verdict = MODE_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            n_tot   <= '0;
            n_lead  <= '0;
            n_trail <= '0;
        end else if (hc_done && !verdict_rdy) begin
            n_tot   <= n_tot + CW'(1);
            n_lead  <= lead_nx;
            n_trail <= trail_nx;
        end
    end

endmodule

// File: rtl/dc_vote_filter.sv
module dc_vote_filter
    import dimclass_pkg::*;
#(
    parameter int VAL_HC   = 16,
    parameter int MISS_LIM = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      hc_done,
    input  dim_mode_e hc_cls,
    input  dim_mode_e cur_mode,
    output logic      trip
);
    localparam int IW = $clog2(VAL_HC + 1);
    localparam int MW = $clog2(MISS_LIM + 1);

    logic [IW-1:0] ivl;
    logic [MW-1:0] miss;
    logic          check, agree;

    always_comb begin
        check = hc_done && (ivl == IW'(VAL_HC - 1));
        agree = (hc_cls == cur_mode);
        trip  = check && !agree && (miss == MW'(MISS_LIM - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ivl  <= '0;
            miss <= '0;
        end else if (hc_done) begin
            if (check) begin
                ivl <= '0;
                if (agree)                     miss <= '0;
                else if (miss != MW'(MISS_LIM)) miss <= miss + MW'(1);
            end else begin
                ivl <= ivl + IW'(1);
            end
        end
    end

endmodule

// File: rtl/dimmer_classifier.sv
module dimmer_classifier
    import dimclass_pkg::*;
#(
    parameter int SMP_W    = 10,
    parameter int LEAD_WIN = 3,
    parameter int LEAD_LVL = 400,
    parameter int SLOPE_TH = 200,
    parameter int LEARN_HC = 4,
    parameter int VAL_HC   = 16,
    parameter int MISS_LIM = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_en,
    input  logic             hc_strobe,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp,
    output logic [1:0]       mode,
    output logic             mode_valid,
    output logic             learning,
    output logic             validating
);
    cls_state_e state, state_nx;
    dim_mode_e  mode_r, mode_nx;
    logic       hc_done;
    dim_mode_e  hc_cls;
    logic       verdict_rdy;
    dim_mode_e  verdict;
    logic       trip;

    dc_edge_probe #(
        .SMP_W   (SMP_W),
        .LEAD_WIN(LEAD_WIN),
        .LEAD_LVL(LEAD_LVL),
        .SLOPE_TH(SLOPE_TH)
    ) u_probe (
        .clk      (clk),
        .rst_n    (rst_n),
        .hc_strobe(hc_strobe),
        .smp_valid(smp_valid),
        .smp      (smp),
        .hc_done  (hc_done),
        .hc_cls   (hc_cls)
    );

    dc_learn_tally #(
        .LEARN_HC(LEARN_HC)
    ) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (state != ST_LEARN),
        .hc_done    (hc_done),
        .hc_cls     (hc_cls),
        .verdict_rdy(verdict_rdy),
        .verdict    (verdict)
    );

    dc_vote_filter #(
        .VAL_HC  (VAL_HC),
        .MISS_LIM(MISS_LIM)
    ) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state != ST_VALID),
        .hc_done (hc_done),
        .hc_cls  (hc_cls),
        .cur_mode(mode_r),
        .trip    (trip)
    );

    // next state
    always_comb begin
        state_nx = state;
        mode_nx  = mode_r;
        unique case (state)
            ST_IDLE: begin
                if (start_en) state_nx = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (!start_en)    state_nx = ST_IDLE;
                else if (hc_done) state_nx = ST_LEARN;
            end
            ST_LEARN: begin
                if (!start_en) begin
                    state_nx = ST_IDLE;
                end else if (verdict_rdy) begin
                    state_nx = ST_VALID;
                    mode_nx  = verdict;
                end
            end
            ST_VALID: begin
                if (!start_en) state_nx = ST_IDLE;
                else if (trip) state_nx = ST_LEARN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_r <= MODE_NONE;
        end else begin
            state  <= state_nx;
            mode_r <= mode_nx;
        end
    end

    // outputs
    always_comb begin
        learning   = (state == ST_ALIGN) || (state == ST_LEARN);
        validating = (state == ST_VALID);
        mode_valid = validating;
        mode       = validating ? mode_r : MODE_NONE;
    end

endmodule

// File: rtl/dc_checker.sv
module dc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_en,
    input logic [1:0] mode,
    input logic       mode_valid,
    input logic       learning,
    input logic       validating
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (mode == 2'b00 && !mode_valid && !learning && !validating));

    // R2
    start_learn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_en && !learning && !validating) |=> learning);

    // R2
    learn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        learning |-> !mode_valid);

    // R4
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({learning, validating}) && (mode_valid == validating));

    // R4
    enter_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(validating) |-> $past(learning));

    // R4
    mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (validating && $past(validating)) |-> $stable(mode));

    // R6
    leave_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (validating && start_en) |=> (validating || learning));

    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_en |=> (!learning && !validating && !mode_valid));

endmodule

bind dimmer_classifier dc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_en  (start_en),
    .mode      (mode),
    .mode_valid(mode_valid),
    .learning  (learning),
    .validating(validating)
);

// File: tb/dimmer_classifier_tb.sv
module dimmer_classifier_tb;
    localparam int SMP_W    = 10;
    localparam int LEAD_WIN = 3;
    localparam int LEAD_LVL = 400;
    localparam int SLOPE_TH = 200;
    localparam int LEARN_HC = 4;
    localparam int VAL_HC   = 16;
    localparam int MISS_LIM = 4;
    localparam int HC_LEN   = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_en = 1'b0;
    logic             hc_strobe = 1'b0;
    logic             smp_valid = 1'b0;
    logic [SMP_W-1:0] smp = '0;
    logic [1:0]       mode;
    logic             mode_valid, learning, validating;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dimmer_classifier #(
        .SMP_W(SMP_W), .LEAD_WIN(LEAD_WIN), .LEAD_LVL(LEAD_LVL),
        .SLOPE_TH(SLOPE_TH), .LEARN_HC(LEARN_HC), .VAL_HC(VAL_HC),
        .MISS_LIM(MISS_LIM)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_en(start_en),
        .hc_strobe(hc_strobe), .smp_valid(smp_valid), .smp(smp),
        .mode(mode), .mode_valid(mode_valid),
        .learning(learning), .validating(validating)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int hq[$];
    int lq[$];
    int m_state, m_mode, m_cls, m_ivl, m_miss;
    bit m_done;

    function automatic int classify(input int q[$]);
        bit ld = 0, tr = 0;
        for (int i = 0; i < q.size(); i++) begin
            if (i < LEAD_WIN && q[i] >= LEAD_LVL) ld = 1;
            if (i > 0 && q[i-1] - q[i] > SLOPE_TH) tr = 1;
        end
        return ld ? 1 : (tr ? 2 : 0);
    endfunction

    function automatic int decide(input int q[$]);
        int nl = 0, nt = 0;
        foreach (q[i]) begin
            if (q[i] == 1) nl++;
            if (q[i] == 2) nt++;
        end
        if (2 * nl > LEARN_HC) return 1;
        if (2 * nt > LEARN_HC) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_mode = 0; m_cls = 0; m_done = 0;
            m_ivl = 0; m_miss = 0;
            hq.delete(); lq.delete();
        end else begin
            if (!start_en) m_state = 0;
            else case (m_state)
                0: m_state = 1;
                1: if (m_done) begin m_state = 2; lq.delete(); end
                2: if (m_done) begin
                    lq.push_back(m_cls);
                    if (lq.size() == LEARN_HC) begin
                        m_mode = decide(lq); m_state = 3; m_ivl = 0; m_miss = 0;
                    end
                end
                default: if (m_done) begin
                    m_ivl++;
                    if (m_ivl == VAL_HC) begin
                        m_ivl = 0;
                        if (m_cls == m_mode) m_miss = 0; else m_miss++;
                        if (m_miss == MISS_LIM) begin m_state = 2; lq.delete(); end
                    end
                end
            endcase
            if (hc_strobe) begin
                m_cls = classify(hq); m_done = 1; hq.delete();
            end else m_done = 0;
            if (smp_valid) hq.push_back(int'(smp));
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            chk("R3 mode vs model", int'(mode), (m_state == 3) ? m_mode : 0);
            chk("R2 learning vs model", int'(learning), (m_state == 1 || m_state == 2) ? 1 : 0);
            chk("R6 validating vs model", int'(validating), (m_state == 3) ? 1 : 0);
        end
    end

    // ---------------- stimulus ----------------
    function automatic int wave(input int kind, input int i);
        case (kind)
            0: return (i < 10) ? i * 70 : (19 - i) * 70;        // no dimmer
            1: return (i == 0) ? 0 : 900 - i * 40;               // leading
            2: return (i < 12) ? i * 70 : 0;                     // trailing
            3: return (i == 0) ? 450 : (i == 1) ? 300 : (i == 2) ? 180 : 100;
            default: return (i == 0) ? 0 : (i < 10) ? 900 - i * 20 : 0; // both
        endcase
    endfunction

    task automatic run(input int kind, input int n);
        for (int h = 0; h < n; h++) begin
            for (int i = 0; i < HC_LEN; i++) begin
                @(negedge clk);
                smp_valid = 1'b1;
                smp       = SMP_W'(wave(kind, i));
                hc_strobe = (i == 0);
            end
            @(negedge clk);
            smp_valid = 1'b0;
            hc_strobe = 1'b0;
        end
    endtask

    task automatic blk(input int fill, input int probe);
        run(fill, VAL_HC - 1);
        run(probe, 1);
    endtask

    task automatic restart();
        start_en = 1'b0;
        repeat (2) @(negedge clk);
        start_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_en = 1'b1;
        chk("R1 reset mode", int'(mode), 0);
        chk("R1 reset phase", int'({mode_valid, learning, validating}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle until start", int'({mode_valid, learning, validating}), 0);
        start_en = 1'b1;
        @(negedge clk);
        chk("R2 learning after start", int'(learning), 1);
        run(1, 4);
        chk("R2 no valid mode while learning", int'(mode_valid), 0);
        run(1, 1);
        chk("R4 leading learned valid", int'(mode_valid), 1);
        chk("R4 leading code", int'(mode), 1);
        // validate: first interval already begun by one half
        run(1, VAL_HC - 2); run(2, 1);
        blk(1, 2);
        blk(1, 2);
        blk(2, 1);   // fills disagree, only the probe half counts
        chk("R5 fills ignored, three misses keep mode", int'(mode_valid), 1);
        blk(1, 2);
        blk(1, 2);
        blk(1, 2);
        blk(1, 2);
        chk("R6 agreeing check cleared misses", int'(mode), 1);
        run(2, 1);
        chk("R6 fourth miss returns to learn", int'(learning), 1);
        chk("R6 mode_valid dropped", int'(mode_valid), 0);
        run(2, 3);
        run(2, 1);
        chk("R4 trailing relearned", int'(mode), 2);
        start_en = 1'b0;
        @(negedge clk);
        chk("R7 stop gives idle", int'({mode_valid, learning, validating}), 0);
        chk("R7 stop mode code", int'(mode), 0);
        restart();
        run(3, 5);
        chk("R8 strobe sample is index 0", int'(mode), 1);
        restart();
        run(4, 5);
        chk("R3 leading beats trailing", int'(mode), 1);
        restart();
        run(1, 2); run(2, 2); run(1, 1);
        chk("R4 tie gives no dimmer", int'(mode), 0);
        chk("R4 tie still valid", int'(mode_valid), 1);
        restart();
        run(0, 5);
        chk("R3 smooth line no dimmer", int'(mode), 0);
        chk("R3 smooth line valid", int'(validating), 1);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule